// File: doc/BRIEF.md
# Port-Selectable Collision Indicator

This block turns the collision information of whichever physical signalling port is selected into one collision indication for an Ethernet MAC. A 2-bit select field picks among four ports. Each port reports collision its own way: an external transceiver's collision pair, overlapping transmit and receive activity, overlapping carrier sense and transmit enable, or an external collision input from an encoder/decoder.

The block also drives the output-enable of the tri-state collision pin. The pin is an output for three of the ports. It is an input for the general-purpose serial port, and it is high-impedance while the device sleeps or the pin is disabled. When the attachment-unit port is in use, the transceiver's SQE test burst after each transmitted frame is kept off the collision output by a mask window. When the serial port is in use, a rising external collision during reception raises a single-cycle request to abort the frame being received.

All external activity inputs are re-timed by a synchronizer chain before they are used. The MAC's own transmit and receive status signals are in the block's clock domain.

Top module: `coll_port_mux`

## Requirements
- R1: Each external activity input (`ci_col`, `tp_tx_act`, `tp_rx_act`, `da_crs`, `da_txen`, `ser_col_in`) passes through a two-stage synchronizer. A change is visible on `col_o` after the second rising clock edge and not after the first.
- R2: With `port_sel`=2'b00 (attachment unit), `col_o` follows the synchronized `ci_col`. The twisted-pair and direct-attach inputs have no effect.
- R3: With `port_sel`=2'b01 (twisted pair), `col_o` is high exactly when `tp_tx_act` and `tp_rx_act` are both high.
- R4: With `port_sel`=2'b10 (direct attach), `col_o` is high exactly when `da_crs` and `da_txen` are both high.
- R5: With `port_sel`=2'b11 (serial port), the pin is an input: `col_oe`=0 and `col_o`=0.
- R6: While `sleep_n`=0, `col_oe`=0 and `col_o`=0 for every `port_sel`.
- R7: While `pin_en`=0, `col_oe`=0 and `col_o`=0 for every `port_sel`.
- R8: `col_oe`=1 exactly when `sleep_n`=1, `pin_en`=1 and `port_sel` is not 2'b11. `col_o` is never high while `col_oe` is low.
- R9: With `port_sel`=2'b00, a collision-pair indication is masked from the falling edge of `mac_tx_active` for SQE_BITS*CLKS_PER_BIT clock cycles (40 by default). The first rising edge after the fall counts as cycle 1. The mask holds through cycle 39 and is released at cycle 40.
- R10: The SQE mask affects only the attachment-unit port. A twisted-pair collision inside the window still reaches `col_o`.
- R11: With `port_sel`=2'b11, `sleep_n`=1, `pin_en`=1 and `mac_rx_active`=1, a rising edge of the synchronized `ser_col_in` gives `rx_abort`=1 for exactly one cycle. The pulse appears after the second clock edge following the input change.
- R12: `rx_abort` stays 0 when `mac_rx_active`=0 or when `port_sel` is not 2'b11.
- R13: After reset, `col_o`=0 and `rx_abort`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 2 | Physical port select: 00 attachment unit, 01 twisted pair, 10 direct attach, 11 serial |
| sleep_n | input | 1 | 0 puts the device to sleep; the pin floats |
| pin_en | input | 1 | 1 enables the collision pin |
| ci_col | input | 1 | Collision-pair indication from the external transceiver |
| tp_tx_act | input | 1 | Twisted-pair transmit activity |
| tp_rx_act | input | 1 | Twisted-pair receive activity |
| da_crs | input | 1 | Direct-attach receive carrier sense |
| da_txen | input | 1 | Direct-attach transmit enable |
| ser_col_in | input | 1 | Collision input from the external encoder/decoder (serial port) |
| mac_tx_active | input | 1 | MAC transmit in progress; its falling edge opens the SQE mask |
| mac_rx_active | input | 1 | MAC receive in progress |
| col_o | output | 1 | Collision indication driven onto the pin |
| col_oe | output | 1 | Output-enable for the pin driver |
| rx_abort | output | 1 | Single-cycle request to abort the frame being received |

## Verification
The detection function is driven with a table of port-select values combined with activity patterns. Each pattern puts exactly one input pair, or only half of a pair, high, so a port that looks at the wrong inputs, or ORs instead of ANDs the two halves, gives a visible wrong value. Rows that put the same collision-causing pattern under sleep, pin disable and the serial port show whether the enable gating is complete. Directed runs then time the synchronizer latency, the last masked and first unmasked cycle of the SQE window, a twisted-pair collision inside that window, and the abort pulse with and without an active receive and under a different port.

// File: rtl/coll_pkg.sv
package coll_pkg;

  typedef enum logic [1:0] {
    PS_ATTACH  = 2'b00,
    PS_TWISTED = 2'b01,
    PS_DIRECT  = 2'b10,
    PS_SERIAL  = 2'b11
  } port_sel_e;

  // bit positions inside the synchronized activity vector
  localparam int unsigned A_CI   = 0;
  localparam int unsigned A_TPTX = 1;
  localparam int unsigned A_TPRX = 2;
  localparam int unsigned A_CRS  = 3;
  localparam int unsigned A_TXEN = 4;
  localparam int unsigned A_SCOL = 5;
  localparam int unsigned A_NUM  = 6;

  // raw collision condition of the selected port
  function automatic logic port_detect(input port_sel_e sel, input logic [A_NUM-1:0] a);
    logic r;
    unique case (sel)
      PS_ATTACH:  r = a[A_CI];
      PS_TWISTED: r = a[A_TPTX] & a[A_TPRX];
      PS_DIRECT:  r = a[A_CRS] & a[A_TXEN];
      default:    r = 1'b0;
    endcase
    return r;
  endfunction

  // pin direction: drive only when awake, enabled and not the serial input port
  function automatic logic pin_drives(input port_sel_e sel, input logic awake, input logic en);
    return awake & en & (sel != PS_SERIAL);
  endfunction

  // SQE mask length in clock cycles
  function automatic int unsigned sqe_cycles(input int unsigned bits, input int unsigned cpb);
    return bits * cpb;
  endfunction

endpackage

// File: rtl/coll_sync.sv
module coll_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/coll_sqe_window.sv
module coll_sqe_window #(
  parameter int unsigned WIN = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  output logic mask,
  output logic tx_fall
);

  localparam int unsigned CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] LOAD = CW'(WIN - 1);

  logic          tx_prev;
  logic [CW-1:0] cnt;

  assign tx_fall = tx_prev & ~tx_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_prev <= 1'b0;
      cnt     <= '0;
    end else begin
      tx_prev <= tx_active;
      if (tx_fall)        cnt <= LOAD;
      else if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign mask = tx_fall | (cnt != '0);

endmodule

// File: rtl/coll_abort_gen.sv
module coll_abort_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic col_s,
  input  logic arm,
  output logic abort,
  output logic col_rise
);

  logic col_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_prev <= 1'b0;
    else        col_prev <= col_s;
  end

  assign col_rise = col_s & ~col_prev;
  assign abort    = col_rise & arm;

endmodule

// File: rtl/coll_port_mux.sv
module coll_port_mux #(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned SQE_BITS     = 40,
  parameter int unsigned CLKS_PER_BIT = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] port_sel,
  input  logic       sleep_n,
  input  logic       pin_en,
  input  logic       ci_col,
  input  logic       tp_tx_act,
  input  logic       tp_rx_act,
  input  logic       da_crs,
  input  logic       da_txen,
  input  logic       ser_col_in,
  input  logic       mac_tx_active,
  input  logic       mac_rx_active,
  output logic       col_o,
  output logic       col_oe,
  output logic       rx_abort
);
  import coll_pkg::*;

  localparam int unsigned SQE_WIN = sqe_cycles(SQE_BITS, CLKS_PER_BIT);

  port_sel_e        sel;
  logic [A_NUM-1:0] act_raw;
  logic [A_NUM-1:0] act_s;
  logic             raw_col;
  logic             sqe_mask;
  logic             tx_fall;
  logic             ser_rise;
  logic             abort_arm;

  assign sel = port_sel_e'(port_sel);

  always_comb begin
    act_raw         = '0;
    act_raw[A_CI]   = ci_col;
    act_raw[A_TPTX] = tp_tx_act;
    act_raw[A_TPRX] = tp_rx_act;
    act_raw[A_CRS]  = da_crs;
    act_raw[A_TXEN] = da_txen;
    act_raw[A_SCOL] = ser_col_in;
  end

  coll_sync #(.W(A_NUM), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (act_raw),
    .q     (act_s)
  );

  coll_sqe_window #(.WIN(SQE_WIN)) u_sqe (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_active (mac_tx_active),
    .mask      (sqe_mask),
    .tx_fall   (tx_fall)
  );

  assign abort_arm = (sel == PS_SERIAL) & sleep_n & pin_en & mac_rx_active;

  coll_abort_gen u_abort (
    .clk      (clk),
    .rst_n    (rst_n),
    .col_s    (act_s[A_SCOL]),
    .arm      (abort_arm),
    .abort    (rx_abort),
    .col_rise (ser_rise)
  );

  assign raw_col = port_detect(sel, act_s);
  assign col_oe  = pin_drives(sel, sleep_n, pin_en);
  assign col_o   = col_oe & raw_col & ~((sel == PS_ATTACH) & sqe_mask);

endmodule

// File: rtl/coll_port_mux_chk.sv
module coll_port_mux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] port_sel,
  input logic       sleep_n,
  input logic       pin_en,
  input logic       mac_tx_active,
  input logic       mac_rx_active,
  input logic       col_o,
  input logic       col_oe,
  input logic       rx_abort,
  input logic       sqe_mask,
  input logic       ser_rise
);

  p_serial_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (port_sel == 2'b11) |-> (!col_oe && !col_o));

  p_sleep_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |-> (!col_oe && !col_o));

  p_disable_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en |-> (!col_oe && !col_o));

  p_col_needs_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    col_o |-> col_oe);

  p_mask_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sqe_mask && port_sel == 2'b00) |-> !col_o);

  p_mask_opens_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mac_tx_active) |-> sqe_mask);

  p_abort_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort |=> !rx_abort);

  p_abort_on_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort |-> ser_rise);

  p_abort_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort |-> (mac_rx_active && port_sel == 2'b11));

endmodule

bind coll_port_mux coll_port_mux_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .port_sel      (port_sel),
  .sleep_n       (sleep_n),
  .pin_en        (pin_en),
  .mac_tx_active (mac_tx_active),
  .mac_rx_active (mac_rx_active),
  .col_o         (col_o),
  .col_oe        (col_oe),
  .rx_abort      (rx_abort),
  .sqe_mask      (sqe_mask),
  .ser_rise      (ser_rise)
);

// File: tb/coll_port_mux_tb.sv
module coll_port_mux_tb;

  localparam int unsigned MASK_CYC = 40;
  localparam int NV = 13;
  // {sel[1:0], sleep_n, pin_en, ci, tp_tx, tp_rx, crs, txen, exp_col, exp_oe}
  localparam logic [10:0] VEC [NV] = '{
    11'b00_1_1_1_0_0_0_0_1_1,
    11'b00_1_1_0_1_1_1_1_0_1,
    11'b01_1_1_0_1_1_0_0_1_1,
    11'b01_1_1_1_1_0_0_0_0_1,
    11'b01_1_1_0_0_1_1_1_0_1,
    11'b10_1_1_0_0_0_1_1_1_1,
    11'b10_1_1_1_1_1_1_0_0_1,
    11'b10_1_1_0_0_0_0_1_0_1,
    11'b11_1_1_1_1_1_1_1_0_0,
    11'b00_0_1_1_0_0_0_0_0_0,
    11'b01_0_1_0_1_1_0_0_0_0,
    11'b10_1_0_0_0_0_1_1_0_0,
    11'b00_1_0_1_0_0_0_0_0_0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] port_sel = 2'b00;
  logic sleep_n = 1'b1, pin_en = 1'b1;
  logic ci_col = 0, tp_tx_act = 0, tp_rx_act = 0, da_crs = 0, da_txen = 0, ser_col_in = 0;
  logic mac_tx_active = 0, mac_rx_active = 0;
  logic col_o, col_oe, rx_abort;

  int checks = 0;
  int fails  = 0;
  logic seen;

  always #10 clk = ~clk;

  coll_port_mux u_dut (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .sleep_n(sleep_n), .pin_en(pin_en),
    .ci_col(ci_col), .tp_tx_act(tp_tx_act), .tp_rx_act(tp_rx_act), .da_crs(da_crs),
    .da_txen(da_txen), .ser_col_in(ser_col_in), .mac_tx_active(mac_tx_active),
    .mac_rx_active(mac_rx_active), .col_o(col_o), .col_oe(col_oe), .rx_abort(rx_abort)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    ci_col = 0; tp_tx_act = 0; tp_rx_act = 0; da_crs = 0; da_txen = 0; ser_col_in = 0;
  endtask

  function automatic string row_req(input logic [10:0] v);
    if (!v[8]) return "R6";
    if (!v[7]) return "R7";
    case (v[10:9])
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // reset state (R13)
    edges(3);
    chk("R13", "col_o in reset", col_o, 1'b0);
    chk("R13", "rx_abort in reset", rx_abort, 1'b0);
    rst_n = 1'b1;
    edges(2);
    chk("R13", "col_o after reset", col_o, 1'b0);

    // table walk of detection and pin direction
    for (int i = 0; i < NV; i++) begin
      port_sel = VEC[i][10:9]; sleep_n = VEC[i][8]; pin_en = VEC[i][7];
      ci_col = VEC[i][6]; tp_tx_act = VEC[i][5]; tp_rx_act = VEC[i][4];
      da_crs = VEC[i][3]; da_txen = VEC[i][2];
      edges(3);
      chk(row_req(VEC[i]), $sformatf("col_o row %0d", i), col_o, VEC[i][1]);
      chk((VEC[i][0] ? "R8" : row_req(VEC[i])), $sformatf("col_oe row %0d", i), col_oe, VEC[i][0]);
    end
    quiet(); sleep_n = 1; pin_en = 1;
    edges(3);

    // R1: two-edge synchronizer latency
    port_sel = 2'b01; tp_tx_act = 1; tp_rx_act = 1;
    edges(1);
    chk("R1", "col_o after one edge", col_o, 1'b0);
    edges(1);
    chk("R1", "col_o after two edges", col_o, 1'b1);
    quiet();
    edges(3);

    // R9: SQE mask window boundary
    port_sel = 2'b00; mac_tx_active = 1;
    edges(3);
    mac_tx_active = 0; ci_col = 1;
    edges(3);
    chk("R9", "col_o early in mask", col_o, 1'b0);
    edges(MASK_CYC - 1 - 3);
    chk("R9", "col_o at last masked cycle", col_o, 1'b0);
    edges(1);
    chk("R9", "col_o once mask released", col_o, 1'b1);
    quiet();
    edges(3);

    // R10: twisted pair not masked inside the window
    mac_tx_active = 1;
    edges(3);
    mac_tx_active = 0; port_sel = 2'b01; tp_tx_act = 1; tp_rx_act = 1;
    edges(3);
    chk("R10", "twisted col inside window", col_o, 1'b1);
    quiet();
    edges(MASK_CYC + 3);

    // R11: abort pulse timing and width
    port_sel = 2'b11; mac_rx_active = 1;
    edges(2);
    ser_col_in = 1;
    edges(1);
    chk("R11", "abort after one edge", rx_abort, 1'b0);
    edges(1);
    chk("R11", "abort after two edges", rx_abort, 1'b1);
    edges(1);
    chk("R11", "abort one cycle later", rx_abort, 1'b0);
    ser_col_in = 0;
    edges(4);

    // R12: no abort without active receive
    mac_rx_active = 0; ser_col_in = 1; seen = 0;
    for (int k = 0; k < 5; k++) begin edges(1); seen |= rx_abort; end
    chk("R12", "abort with receive idle", seen, 1'b0);
    ser_col_in = 0;
    edges(4);

    // R12: no abort under another port
    port_sel = 2'b01; mac_rx_active = 1; ser_col_in = 1; seen = 0;
    for (int k = 0; k < 5; k++) begin edges(1); seen |= rx_abort; end
    chk("R12", "abort with twisted port", seen, 1'b0);
    ser_col_in = 0; mac_rx_active = 0;
    edges(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule